// File: doc/BRIEF.md
# CAN Receive Frame FIFO

This block buffers received CAN frames between the serial receive logic and a host. The receive logic streams each frame as bytes: first a header byte, then the identifier bytes, then the data bytes. The block writes these bytes into a byte memory at a shadow position. It keeps the frame only when the frame ends with a good CRC, has the length its header promises, passes the acceptance filter and fits in the free space. Otherwise the shadow position rolls back and the frame is gone.

The host sees the oldest stored frame through a small read window: byte offset 0 is the header. It drops that frame with a release command, which brings the next frame into the window. The host can also empty the whole buffer in one cycle. The block reports the number of stored frames, a data-available flag, a receive-interrupt level that the host can enable, and a sticky overrun flag with its own clear command.

Top module: `can_rx_frame_fifo`

## Requirements
- R1: After synchronous reset, frame_cnt is 0 and data_avail, rx_irq and overrun are low. rd_data reads 0.
- R2: Header byte layout: bit 7 set means extended format, bit 6 set means remote frame, bits 3:0 hold the DLC. A stored record is 1 header byte, then 2 identifier bytes (standard) or 4 (extended), then min(DLC,8) data bytes, with no data bytes for a remote frame. Record offset k shows on rd_data one cycle after rd_addr is set to k.
- R3: The identifier bytes form a 32-bit value, with the first identifier byte in bits 31:24. A mask bit of 1 marks that position as don't care. A standard frame compares only bits 31:16. A frame that mismatches in any compared bit is not stored.
- R4: A frame that ends with wr_crc_ok low, or whose byte count differs from its header's record length, is discarded. frame_cnt does not change.
- R5: release_frame drops the oldest frame, decrements frame_cnt and presents the next frame in arrival order. On an empty buffer it has no effect.
- R6: clear_buf empties the buffer in one cycle: frame_cnt becomes 0 and every window offset reads 0 until a new frame is stored. Repeated clears keep it empty.
- R7: A frame whose record is longer than the free space (DEPTH minus the stored bytes) is discarded and sets overrun. Frames already stored stay intact. overrun stays set until cleared.
- R8: clear_ovr resets overrun and leaves the stored frames and frame_cnt unchanged.
- R9: data_avail is high exactly when frame_cnt is non-zero. rx_irq is data_avail gated by irq_en.
- R10: The default 64-byte store holds five standard 8-byte frames (11 bytes each). When space is freed, further frames are accepted, and frames are handed over in order across the memory wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_code | input | 32 | Acceptance code |
| acc_mask | input | 32 | Acceptance mask, 1 = don't care |
| wr_start | input | 1 | Start of an incoming frame |
| wr_valid | input | 1 | wr_byte holds the next frame byte |
| wr_byte | input | 8 | Frame byte from the receive logic |
| wr_end | input | 1 | End of the incoming frame |
| wr_crc_ok | input | 1 | CRC result, sampled with wr_end |
| rd_addr | input | WIN_AW | Byte offset in the oldest frame |
| rd_data | output | 8 | Byte at rd_addr, one cycle later |
| release_frame | input | 1 | Drop the oldest frame |
| clear_buf | input | 1 | Empty the whole buffer |
| clear_ovr | input | 1 | Clear the overrun flag |
| irq_en | input | 1 | Receive-interrupt enable |
| frame_cnt | output | CW | Number of stored frames |
| data_avail | output | 1 | At least one frame stored |
| overrun | output | 1 | Sticky overflow flag |
| rx_irq | output | 1 | Receive-interrupt level |

## Verification
Wrong bookkeeping of the stored-byte count or the release step does not show up as a bad flag. It shows up as a wrong byte in the read window, and only when a later frame, or a frame that crosses the memory wrap, is read. The bench therefore compares every byte of every record it reads, including reads after several releases and after the write position has wrapped. A wrong rollback of the shadow position shows on the next accepted frame. Errors in filtering or in the overflow decision change frame_cnt in the cycle after wr_end.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  localparam int HDR_EXT = 7;
  localparam int HDR_RTR = 6;
  localparam int LEN_W   = 4;
  localparam int ID_W    = 32;

  // Record length (header + identifier + data bytes) from a header byte.
  function automatic logic [LEN_W-1:0] rec_len(input logic [7:0] hdr);
    logic [LEN_W-1:0] dbytes;
    dbytes = (hdr[3:0] > 4'd8) ? 4'd8 : hdr[3:0];
    if (hdr[HDR_RTR]) dbytes = '0;
    return 4'd1 + (hdr[HDR_EXT] ? 4'd4 : 4'd2) + dbytes;
  endfunction
endpackage

// File: rtl/can_rxf_ram.sv
module can_rxf_ram #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/can_rxf_lenq.sv
module can_rxf_lenq #(
  parameter int ENTRIES = 21,
  parameter int LW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          pop,
  output logic [LW-1:0] head_len
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [LW-1:0] q [ENTRIES];
  logic [IW-1:0] wr_i, rd_i;

  always_ff @(posedge clk) begin
    if (push) q[wr_i] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_i <= '0;
      rd_i <= '0;
    end else begin
      if (push) wr_i <= (wr_i == LAST) ? '0 : wr_i + 1'b1;
      if (pop)  rd_i <= (rd_i == LAST) ? '0 : rd_i + 1'b1;
    end
  end

  assign head_len = q[rd_i];
endmodule

// File: rtl/can_rxf_filter.sv
module can_rxf_filter #(
  parameter int IDW = 32
) (
  input  logic [IDW-1:0] id_raw,
  input  logic           ext,
  input  logic [IDW-1:0] code,
  input  logic [IDW-1:0] mask,
  output logic           accept
);
  localparam int HALF = IDW / 2;
  logic [IDW-1:0] id_al, diff;

  // Standard frames carry half the identifier bytes, left-aligned here.
  assign id_al = ext ? id_raw : {id_raw[HALF-1:0], {HALF{1'b0}}};
  assign diff  = (id_al ^ code) & ~mask;

  always_comb begin
    if (ext) accept = (diff == '0);
    else     accept = (diff[IDW-1:HALF] == '0);
  end
endmodule

// File: rtl/can_rx_frame_fifo.sv
module can_rx_frame_fifo
  import can_rxf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WIN_AW = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int MAXF  = DEPTH / 3,
  localparam int CW    = $clog2(MAXF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   acc_code,
  input  logic [ID_W-1:0]   acc_mask,
  input  logic              wr_start,
  input  logic              wr_valid,
  input  logic [7:0]        wr_byte,
  input  logic              wr_end,
  input  logic              wr_crc_ok,
  input  logic [WIN_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              release_frame,
  input  logic              clear_buf,
  input  logic              clear_ovr,
  input  logic              irq_en,
  output logic [CW-1:0]     frame_cnt,
  output logic              data_avail,
  output logic              overrun,
  output logic              rx_irq
);
  // Incoming frame state
  logic             active, fit_q, ext_q;
  logic [AW-1:0]    sh_ptr;
  logic [LEN_W-1:0] bcnt, flen_q;
  logic [ID_W-1:0]  id_q;

  // Committed state
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      used;
  logic             zero_q;

  logic [LEN_W-1:0] hdr_len, head_len;
  logic [AW:0]      free_b;
  logic             is_hdr, fit_now, mem_we, is_id;
  logic             accept, len_ok, commit_ok, ovr_set, rel_ok;
  logic [CW-1:0]    cnt_nx;
  logic [AW-1:0]    raddr;
  logic [7:0]       ram_q;

  always_comb begin
    hdr_len = rec_len(wr_byte);
    free_b  = (AW+1)'(DEPTH) - used;
    is_hdr  = active && wr_valid && (bcnt == '0);
    fit_now = is_hdr ? ((AW+1)'(hdr_len) <= free_b) : fit_q;
    mem_we  = active && wr_valid && !clear_buf && fit_now &&
              (is_hdr || (bcnt < flen_q));
    is_id   = (bcnt != '0) && (bcnt <= (ext_q ? 4'd4 : 4'd2));
    len_ok  = (flen_q != '0) && (bcnt == flen_q);
    commit_ok = active && wr_end && wr_crc_ok && len_ok && accept && fit_q && !clear_buf;
    ovr_set   = active && wr_end && wr_crc_ok && len_ok && accept && !fit_q;
    rel_ok    = release_frame && (frame_cnt != '0) && !clear_buf;
    cnt_nx    = frame_cnt + CW'(commit_ok) - CW'(rel_ok);
    raddr     = rd_ptr + AW'(rd_addr);
  end

  can_rxf_filter #(.IDW(ID_W)) i_filter (
    .id_raw (id_q),
    .ext    (ext_q),
    .code   (acc_code),
    .mask   (acc_mask),
    .accept (accept)
  );

  can_rxf_ram #(.DW(8), .AW(AW)) i_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (sh_ptr),
    .wdata (wr_byte),
    .raddr (raddr),
    .rdata (ram_q)
  );

  can_rxf_lenq #(.ENTRIES(MAXF), .LW(LEN_W)) i_lenq (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear_buf),
    .push     (commit_ok),
    .push_len (flen_q),
    .pop      (rel_ok),
    .head_len (head_len)
  );

  // Speculative write side: shadow pointer restarts at the committed one.
  always_ff @(posedge clk) begin
    if (rst || clear_buf) begin
      active <= 1'b0;
      sh_ptr <= '0;
      bcnt   <= '0;
      flen_q <= '0;
      fit_q  <= 1'b0;
      ext_q  <= 1'b0;
      id_q   <= '0;
    end else if (wr_start) begin
      active <= 1'b1;
      sh_ptr <= wr_ptr;
      bcnt   <= '0;
      flen_q <= '0;
      fit_q  <= 1'b0;
      ext_q  <= 1'b0;
      id_q   <= '0;
    end else if (active && wr_valid) begin
      if (bcnt != '1) bcnt <= bcnt + 1'b1;
      if (is_hdr) begin
        flen_q <= hdr_len;
        fit_q  <= fit_now;
        ext_q  <= wr_byte[HDR_EXT];
      end
      if (is_id) id_q <= {id_q[ID_W-9:0], wr_byte};
      if (mem_we) sh_ptr <= sh_ptr + 1'b1;
    end else if (wr_end) begin
      active <= 1'b0;
    end
  end

  // Committed pointers and counts
  always_ff @(posedge clk) begin
    if (rst || clear_buf) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      used       <= '0;
      frame_cnt  <= '0;
      data_avail <= 1'b0;
      rx_irq     <= 1'b0;
      zero_q     <= 1'b1;
    end else begin
      if (commit_ok) wr_ptr <= wr_ptr + AW'(flen_q);
      if (rel_ok)    rd_ptr <= rd_ptr + AW'(head_len);
      used       <= used + (commit_ok ? (AW+1)'(flen_q) : '0)
                         - (rel_ok    ? (AW+1)'(head_len) : '0);
      frame_cnt  <= cnt_nx;
      data_avail <= (cnt_nx != '0);
      rx_irq     <= (cnt_nx != '0) && irq_en;
      zero_q     <= (frame_cnt == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            overrun <= 1'b0;
    else if (ovr_set)   overrun <= 1'b1;
    else if (clear_ovr) overrun <= 1'b0;
  end

  assign rd_data = zero_q ? 8'h00 : ram_q;
endmodule

// File: rtl/can_rx_frame_fifo_chk.sv
module can_rx_frame_fifo_chk #(
  parameter int CW   = 5,
  parameter int MAXF = 21
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_end,
  input logic          wr_crc_ok,
  input logic          release_frame,
  input logic          clear_buf,
  input logic          clear_ovr,
  input logic [CW-1:0] frame_cnt,
  input logic          data_avail,
  input logic          overrun,
  input logic          rx_irq
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (frame_cnt == '0 && !overrun && !data_avail));

  p_crc_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_end && !wr_crc_ok && !release_frame && !clear_buf) |=> frame_cnt == $past(frame_cnt));

  p_release_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (release_frame && frame_cnt != '0 && !wr_end && !clear_buf) |=>
      frame_cnt == $past(frame_cnt) - 1'b1);

  p_clear_empty_r6: assert property (@(posedge clk) disable iff (rst)
    clear_buf |=> (frame_cnt == '0 && !data_avail && !rx_irq));

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (overrun && !clear_ovr) |=> overrun);

  p_ovr_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clear_ovr && !wr_end) |=> !overrun);

  p_avail_r9: assert property (@(posedge clk) disable iff (rst)
    data_avail == (frame_cnt != '0));

  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> data_avail);

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    frame_cnt <= CW'(MAXF));
endmodule

bind can_rx_frame_fifo can_rx_frame_fifo_chk #(.CW(CW), .MAXF(MAXF)) i_chk (.*);

// File: tb/test_can_rx_frame_fifo.sv
module test_can_rx_frame_fifo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] acc_code = 32'h1234_0000;
  logic [31:0] acc_mask = 32'h0000_FFFF;
  logic        wr_start = 0, wr_valid = 0, wr_end = 0, wr_crc_ok = 0;
  logic [7:0]  wr_byte = 0;
  logic [3:0]  rd_addr = 0;
  logic [7:0]  rd_data;
  logic        release_frame = 0, clear_buf = 0, clear_ovr = 0, irq_en = 1;
  logic [4:0]  frame_cnt;
  logic        data_avail, overrun, rx_irq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  can_rx_frame_fifo i_can_rx_frame_fifo (
    .clk(clk), .rst(rst), .acc_code(acc_code), .acc_mask(acc_mask),
    .wr_start(wr_start), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .wr_end(wr_end), .wr_crc_ok(wr_crc_ok), .rd_addr(rd_addr),
    .rd_data(rd_data), .release_frame(release_frame), .clear_buf(clear_buf),
    .clear_ovr(clear_ovr), .irq_en(irq_en), .frame_cnt(frame_cnt),
    .data_avail(data_avail), .overrun(overrun), .rx_irq(rx_irq)
  );

  // hdr, id, data, crc_ok, expect_stored
  localparam int NV = 7;
  localparam logic [105:0] VEC [NV] = '{
    {8'h02, 32'h1234_0000, 64'hAABB_0000_0000_0000, 1'b1, 1'b1},
    {8'h88, 32'h1234_ABCD, 64'h0102_0304_0506_0708, 1'b1, 1'b1},
    {8'h03, 32'h1235_0000, 64'h1111_1111_1111_1111, 1'b1, 1'b0},
    {8'h01, 32'h1234_0000, 64'h2222_2222_2222_2222, 1'b0, 1'b0},
    {8'h4F, 32'h1234_0000, 64'h3333_3333_3333_3333, 1'b1, 1'b1},
    {8'h8C, 32'h1234_9999, 64'h1122_3344_5566_7788, 1'b1, 1'b1},
    {8'h88, 32'h2234_0000, 64'h4444_4444_4444_4444, 1'b1, 1'b0}
  };

  function automatic int rlen(input logic [7:0] h);
    int d;
    d = (h[3:0] > 8) ? 8 : int'(h[3:0]);
    if (h[6]) d = 0;
    return 1 + (h[7] ? 4 : 2) + d;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] h, input logic [31:0] id,
                                          input logic [63:0] dat, input int off);
    int n;
    n = h[7] ? 4 : 2;
    if (off == 0) return h;
    if (off <= n) return 8'(id >> (8 * (4 - off)));
    return 8'(dat >> (8 * (7 - (off - 1 - n))));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] h, input logic [31:0] id, input logic [63:0] dat,
                      input logic crc, input int delta);
    int n;
    n = rlen(h) + delta;
    @(negedge clk); wr_start = 1;
    @(negedge clk); wr_start = 0;
    for (int k = 0; k < n; k++) begin
      wr_valid = 1;
      wr_byte  = (k < rlen(h)) ? exp_byte(h, id, dat, k) : 8'h5A;
      @(negedge clk);
    end
    wr_valid = 0; wr_end = 1; wr_crc_ok = crc;
    @(negedge clk); wr_end = 0; wr_crc_ok = 0;
  endtask

  task automatic rd(input int off, output logic [7:0] v);
    rd_addr = 4'(off);
    @(negedge clk);
    v = rd_data;
  endtask

  // Compare a whole record in the window; one check.
  task automatic check_rec(input string req, input logic [7:0] h, input logic [31:0] id,
                           input logic [63:0] dat);
    logic [7:0] v;
    int bad, first_a, first_e;
    bad = 0; first_a = 0; first_e = 0;
    for (int k = 0; k < rlen(h); k++) begin
      rd(k, v);
      if (v != exp_byte(h, id, dat, k) && bad == 0) begin
        bad = 1; first_a = v; first_e = exp_byte(h, id, dat, k);
      end
    end
    check(req, first_a, first_e);
  endtask

  task automatic pulse_rel();
    release_frame = 1; @(negedge clk); release_frame = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 frame_cnt", frame_cnt, 0);
    check("R1 flags", {data_avail, rx_irq, overrun}, 0);
    rd(0, v); check("R1 rd_data", v, 0);

    // Vector walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][105:98], VEC[i][97:66], VEC[i][65:2], VEC[i][1], 0);
      check(VEC[i][0] ? "R2 stored" : "R3/R4 dropped", frame_cnt, VEC[i][0]);
      if (VEC[i][0]) begin
        check("R9 irq", {data_avail, rx_irq}, 2'b11);
        check_rec("R2 record", VEC[i][105:98], VEC[i][97:66], VEC[i][65:2]);
        pulse_rel();
        check("R5 released", frame_cnt, 0);
      end
    end

    // R4: short and long byte counts
    send(8'h02, 32'h1234_0000, 64'h0, 1'b1, -1);
    check("R4 short", frame_cnt, 0);
    send(8'h02, 32'h1234_0000, 64'h0, 1'b1, 1);
    check("R4 long", frame_cnt, 0);

    // R5: release on empty
    pulse_rel();
    check("R5 empty release", frame_cnt, 0);

    // R10 fill with five 11-byte frames
    for (int i = 0; i < 5; i++)
      send(8'h08, 32'h1234_0000, {8{8'(8'h10 + i)}}, 1'b1, 0);
    check("R10 five stored", frame_cnt, 5);
    // R7 overflow
    send(8'h08, 32'h1234_0000, {8{8'hEE}}, 1'b1, 0);
    check("R7 cnt kept", frame_cnt, 5);
    check("R7 overrun", overrun, 1);
    check_rec("R7 head intact", 8'h08, 32'h1234_0000, {8{8'h10}});
    // R8
    clear_ovr = 1; @(negedge clk); clear_ovr = 0;
    check("R8 overrun cleared", overrun, 0);
    check("R8 cnt kept", frame_cnt, 5);
    // R10 free two, add one across wrap, drain in order
    pulse_rel(); pulse_rel();
    send(8'h08, 32'h1234_0000, {8{8'hEE}}, 1'b1, 0);
    check("R10 refill", frame_cnt, 4);
    for (int i = 2; i < 5; i++) begin
      check_rec("R10 order", 8'h08, 32'h1234_0000, {8{8'(8'h10 + i)}});
      pulse_rel();
    end
    check_rec("R10 wrap frame", 8'h08, 32'h1234_0000, {8{8'hEE}});
    pulse_rel();
    check("R10 drained", frame_cnt, 0);

    // R9 irq gating
    irq_en = 0;
    send(8'h01, 32'h1234_0000, 64'h7700_0000_0000_0000, 1'b1, 0);
    check("R9 gated", {data_avail, rx_irq}, 2'b10);
    irq_en = 1;

    // R6 clear, repeated
    send(8'h88, 32'h1234_5678, 64'h0, 1'b1, 0);
    for (int c = 0; c < 2; c++) begin
      clear_buf = 1; @(negedge clk); clear_buf = 0;
      check("R6 cnt zero", frame_cnt, 0);
      check("R6 avail low", data_avail, 0);
      begin
        int nz;
        nz = 0;
        for (int k = 0; k < 16; k++) begin rd(k, v); if (v != 0) nz = v; end
        check("R6 window zero", nz, 0);
      end
    end
    send(8'h02, 32'h1234_0000, 64'hC0DE_0000_0000_0000, 1'b1, 0);
    check_rec("R6 fresh frame", 8'h02, 32'h1234_0000, 64'hC0DE_0000_0000_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule